// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block controls how a multi-output clock generator enters and leaves its low-power state. A power-down pin, active low and asynchronous to everything, is brought into the internal CPU clock domain through a two-flop synchronizer. When a power-down request arrives, the block first parks every output clock low. It holds them there for a short, parameterised interval. Only then does it drop the VCO enable and the oscillator enable.

When the pin is released, the block turns the oscillator and VCOs back on. It then counts rising edges of the reference clock until a stabilisation interval has passed, and only after that does it let the output clocks run. The default interval is just under 3 ms at 14.318 MHz. The PLLs, the oscillator and the output buffers are outside this block. The block only drives their enables.

While the generator runs, the CPU-stop and PCI-stop pins gate their clock groups. Each PCI output can be made free-running so that PCI-stop does not affect it. A tri-state configuration bit switches the drivers of all outputs off at any time.

Top module: `pd_seq`

## Requirements
- R1: While reset is asserted, and after it until the first wake, the block reports the off state (`pd_off_o`=1), holds `osc_en_o` and `vco_en_o` at 0, and holds every run output at 0.
- R2: `pd_n_i` passes through a two-flop synchronizer. If the pin is driven low just after a falling clock edge, the run outputs are still 1 after the second rising edge and are all 0 after the third.
- R3: On entry to power-down, the outputs are parked low while `osc_en_o`/`vco_en_o` stay 1 for exactly PARK_CYCLES cycles. After that, both enables go to 0 and `pd_off_o` goes to 1. The enables are never 0 while any run output is 1.
- R4: When `pd_n_i` rises just after a falling clock edge, `osc_en_o`/`vco_en_o` are still 0 after the second rising edge and are 1 after the third. The outputs stay parked until WAKE_REFS rising edges of `ref_clk_i` have been counted, give or take one edge for synchronizer phase.
- R5: If a power-down request arrives while the block is waiting for the clocks to stabilise, it returns to parking and then to off, and no run output ever goes to 1 in between.
- R6: Whenever the block is not in its running state, `cpu_stop_n_i`, `pci_stop_n_i` and `pci_free_i` have no effect on any output.
- R7: While running, `cpu_run_o` equals the synchronized `cpu_stop_n_i`, where 1 means the clock runs.
- R8: While running, bit i of `pci_run_o` is 1 when the synchronized `pci_stop_n_i` is 1 or when `pci_free_i[i]` is 1.
- R9: While running, `fix_run_o` (the reference, 48 MHz and 24/48 MHz group) is 1 no matter what the stop inputs do.
- R10: `drv_en_o` is the inverse of `tristate_all_i` in every state. A value of 1 on the input tri-states all outputs.
- R11: Once parking has started, it always runs through to the off state, even if `pd_n_i` goes high again during parking. With PARK_CYCLES=2, `pd_off_o` is 1 after the fifth rising edge following the pin's fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | Internal CPU clock; all sequencing runs on it |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_n_i | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n_i | input | 1 | Asynchronous CPU clock stop, active low |
| pci_stop_n_i | input | 1 | Asynchronous PCI clock stop, active low |
| ref_clk_i | input | 1 | Reference clock whose rising edges time the wake-up wait |
| pci_free_i | input | NUM_PCI | Per-output free-run select (1 = ignore PCI stop) |
| tristate_all_i | input | 1 | Configuration bit: 1 tri-states all outputs |
| cpu_run_o | output | 1 | 1 = CPU clock toggles, 0 = parked low |
| pci_run_o | output | NUM_PCI | Per-output PCI clock run enables |
| fix_run_o | output | 1 | Run enable for the reference and USB-rate outputs |
| drv_en_o | output | 1 | Output driver enable (0 = high impedance) |
| vco_en_o | output | 1 | VCO enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| pd_off_o | output | 1 | 1 while the block is fully powered down |

## Verification
The assertions assume that `pd_n_i` may change at any time but that its level is meaningful only over several clock cycles, since the latency property counts three sampled lows. They also assume that `ref_clk_i` is slower than the CPU clock, so that every reference edge can be seen through the synchronizer. The stimulus changes every pin just after a falling clock edge. The reference clock is kept at about one seventh of the CPU rate, with a phase that never coincides with a CPU edge. The stop and free-run pins are randomised both inside and outside the running state, so the masking property is exercised.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PARK = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pd_sync.sv
// Two-stage synchronizer bank for asynchronous level inputs.
module pd_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      hold_q <= meta_q;
    end
  end

  assign sync_o = hold_q;
endmodule

// File: rtl/pd_fsm.sv
// Sequencing state machine: park hold counter and wake-up reference-edge counter.
module pd_fsm
  import pd_seq_pkg::*;
#(
  parameter int PARK_CYCLES = 2,
  parameter int WAKE_REFS   = 42900
) (
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  logic      pd_req_i,
  input  logic      ref_lvl_i,
  output pd_state_e state_o
);
  localparam int PARK_W = $clog2(PARK_CYCLES + 1);
  localparam int WAKE_W = $clog2(WAKE_REFS + 1);
  localparam logic [PARK_W-1:0] PARK_LAST = PARK_W'(PARK_CYCLES - 1);
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_REFS - 1);

  pd_state_e         state_q, state_d;
  logic [PARK_W-1:0] park_q, park_d;
  logic [WAKE_W-1:0] wake_q, wake_d;
  logic              ref_prev_q;
  logic              ref_rise;

  assign ref_rise = ref_lvl_i & ~ref_prev_q;

  always_comb begin
    state_d = state_q;
    park_d  = park_q;
    wake_d  = wake_q;
    unique case (state_q)
      ST_RUN: begin
        if (pd_req_i) begin
          state_d = ST_PARK;
          park_d  = '0;
        end
      end
      ST_PARK: begin
        if (park_q == PARK_LAST) state_d = ST_OFF;
        else                     park_d  = park_q + PARK_W'(1);
      end
      ST_OFF: begin
        if (!pd_req_i) begin
          state_d = ST_WAKE;
          wake_d  = '0;
        end
      end
      ST_WAKE: begin
        if (pd_req_i) begin
          state_d = ST_PARK;
          park_d  = '0;
        end else if (ref_rise) begin
          if (wake_q == WAKE_LAST) state_d = ST_RUN;
          else                     wake_d  = wake_q + WAKE_W'(1);
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q    <= ST_OFF;
      park_q     <= '0;
      wake_q     <= '0;
      ref_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      park_q     <= park_d;
      wake_q     <= wake_d;
      ref_prev_q <= ref_lvl_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pd_gate.sv
// Decodes sequencer state and synchronized stop levels into output enables.
module pd_gate
  import pd_seq_pkg::*;
#(
  parameter int NUM_PCI = 7
) (
  input  pd_state_e    state_i,
  input  logic         cpu_go_i,
  input  logic         pci_go_i,
  input  logic [NUM_PCI-1:0] pci_free_i,
  input  logic         tristate_i,
  output logic         cpu_run_o,
  output logic [NUM_PCI-1:0] pci_run_o,
  output logic         fix_run_o,
  output logic         drv_en_o,
  output logic         vco_en_o,
  output logic         osc_en_o,
  output logic         off_o
);
  logic running;

  assign running   = (state_i == ST_RUN);
  assign cpu_run_o = running & cpu_go_i;
  assign fix_run_o = running;
  assign off_o     = (state_i == ST_OFF);
  assign osc_en_o  = ~off_o;
  assign vco_en_o  = ~off_o;
  assign drv_en_o  = ~tristate_i;

  for (genvar g = 0; g < NUM_PCI; g++) begin : g_pci
    assign pci_run_o[g] = running & (pci_go_i | pci_free_i[g]);
  end
endmodule

// File: rtl/pd_seq.sv
// Top: clock power-down sequencer.
module pd_seq
  import pd_seq_pkg::*;
#(
  parameter int NUM_PCI     = 7,
  parameter int PARK_CYCLES = 2,
  parameter int WAKE_REFS   = 42900
) (
  input  logic               clk_cpu_i,
  input  logic               rst_n_i,
  input  logic               pd_n_i,
  input  logic               cpu_stop_n_i,
  input  logic               pci_stop_n_i,
  input  logic               ref_clk_i,
  input  logic [NUM_PCI-1:0] pci_free_i,
  input  logic               tristate_all_i,
  output logic               cpu_run_o,
  output logic [NUM_PCI-1:0] pci_run_o,
  output logic               fix_run_o,
  output logic               drv_en_o,
  output logic               vco_en_o,
  output logic               osc_en_o,
  output logic               pd_off_o
);
  localparam int SYNC_W = 4;

  logic              rst_meta_q, rst_core_n_q;
  logic [SYNC_W-1:0] sync_lvl;
  pd_state_e         state;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk_cpu_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q   <= 1'b0;
      rst_core_n_q <= 1'b0;
    end else begin
      rst_meta_q   <= 1'b1;
      rst_core_n_q <= rst_meta_q;
    end
  end

  // bit 0: power-down pin, 1: CPU stop, 2: PCI stop, 3: reference clock
  pd_sync #(
    .WIDTH  (SYNC_W),
    .RST_VAL(4'b0000)
  ) sync_i (
    .clk_i  (clk_cpu_i),
    .rst_n_i(rst_core_n_q),
    .async_i({ref_clk_i, pci_stop_n_i, cpu_stop_n_i, pd_n_i}),
    .sync_o (sync_lvl)
  );

  pd_fsm #(
    .PARK_CYCLES(PARK_CYCLES),
    .WAKE_REFS  (WAKE_REFS)
  ) fsm_i (
    .clk_i    (clk_cpu_i),
    .rst_n_i  (rst_core_n_q),
    .pd_req_i (~sync_lvl[0]),
    .ref_lvl_i(sync_lvl[3]),
    .state_o  (state)
  );

  pd_gate #(
    .NUM_PCI(NUM_PCI)
  ) gate_i (
    .state_i   (state),
    .cpu_go_i  (sync_lvl[1]),
    .pci_go_i  (sync_lvl[2]),
    .pci_free_i(pci_free_i),
    .tristate_i(tristate_all_i),
    .cpu_run_o (cpu_run_o),
    .pci_run_o (pci_run_o),
    .fix_run_o (fix_run_o),
    .drv_en_o  (drv_en_o),
    .vco_en_o  (vco_en_o),
    .osc_en_o  (osc_en_o),
    .off_o     (pd_off_o)
  );
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk #(
  parameter int NUM_PCI = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pd_n,
  input logic               cpu_run,
  input logic [NUM_PCI-1:0] pci_run,
  input logic               fix_run,
  input logic               vco_en,
  input logic               osc_en,
  input logic               pd_off
);
  logic any_run;
  assign any_run = cpu_run | (|pci_run) | fix_run;

  assert_entry_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n && $past(!pd_n) && $past(!pd_n, 2)) |=> !any_run);

  assert_parked_before_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(!any_run));

  assert_no_run_without_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en || !vco_en) |-> !any_run);

  assert_off_means_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pd_off |-> (!osc_en && !vco_en));

  assert_release_after_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fix_run) |-> ($past(osc_en) && $past(vco_en)));

  assert_stops_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_run |-> (!cpu_run && pci_run == '0));
endmodule

bind pd_seq pd_seq_chk #(.NUM_PCI(NUM_PCI)) chk_i (
  .clk    (clk_cpu_i),
  .rst_n  (rst_n_i),
  .pd_n   (pd_n_i),
  .cpu_run(cpu_run_o),
  .pci_run(pci_run_o),
  .fix_run(fix_run_o),
  .vco_en (vco_en_o),
  .osc_en (osc_en_o),
  .pd_off (pd_off_o)
);

// File: tb/pd_seq_tb_top.sv
module pd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 7;
  localparam int PARK       = 2;
  localparam int WREFS      = 6;

  logic          clk = 1'b0;
  logic          ref_clk = 1'b0;
  logic          rst_n, pd_n, cpu_stop_n, pci_stop_n, tri_all;
  logic [NP-1:0] pci_free;
  logic          cpu_run, fix_run, drv_en, vco_en, osc_en, pd_off;
  logic [NP-1:0] pci_run;

  int checks = 0;
  int fails  = 0;
  int ref_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #2;
    forever #36 ref_clk = ~ref_clk;
  end
  always @(posedge ref_clk) ref_cnt++;

  pd_seq #(.NUM_PCI(NP), .PARK_CYCLES(PARK), .WAKE_REFS(WREFS)) dut_i (
    .clk_cpu_i(clk), .rst_n_i(rst_n), .pd_n_i(pd_n),
    .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n), .ref_clk_i(ref_clk),
    .pci_free_i(pci_free), .tristate_all_i(tri_all),
    .cpu_run_o(cpu_run), .pci_run_o(pci_run), .fix_run_o(fix_run),
    .drv_en_o(drv_en), .vco_en_o(vco_en), .osc_en_o(osc_en), .pd_off_o(pd_off));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] exp_pci(input logic stop_n, input logic [NP-1:0] fr);
    return fr | {NP{stop_n}};
  endfunction

  function automatic logic [31:0] parked_word(input logic c, input logic [NP-1:0] p, input logic f);
    return {23'd0, c, p, f};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // wake from OFF with cycle-exact enable timing and bounded ref-edge wait
  task automatic wake(input string tag);
    int r0, r1, guard;
    pd_n = 1'b1;
    step(2);
    chk({tag, " R4 osc still off after 2 edges"}, {30'd0, osc_en, vco_en}, 32'd0);
    step(1);
    chk({tag, " R4 osc/vco on after 3rd edge"}, {30'd0, osc_en, vco_en}, 32'd3);
    chk({tag, " R4 outputs parked during wait"}, parked_word(cpu_run, pci_run, fix_run), 32'd0);
    r0 = ref_cnt;
    guard = 0;
    while (!fix_run && guard < 2000) begin
      step(1);
      guard++;
    end
    r1 = ref_cnt;
    chk({tag, " R4 released"}, {31'd0, fix_run}, 32'd1);
    chk({tag, " R4 ref edges in window"},
        {31'd0, ((r1 - r0) >= WREFS - 1) && ((r1 - r0) <= WREFS + 1)}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h00C10C4D));
    rst_n = 1'b0; pd_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    tri_all = 1'b0; pci_free = '0;
    step(3);
    // R1: reset state
    chk("R1 off status in reset", {31'd0, pd_off}, 32'd1);
    chk("R1 enables low in reset", {30'd0, osc_en, vco_en}, 32'd0);
    chk("R1 run outputs low in reset", parked_word(cpu_run, pci_run, fix_run), 32'd0);
    rst_n = 1'b1;
    step(6);
    chk("R1 stays off after reset", {30'd0, pd_off, osc_en}, 32'd2);

    wake("first");

    // R7 R8 R9 R10: random stop/free-run/tri-state patterns while running
    for (int i = 0; i < 40; i++) begin
      cpu_stop_n = 1'($urandom);
      pci_stop_n = 1'($urandom);
      pci_free   = NP'($urandom);
      tri_all    = 1'($urandom);
      step(3);
      chk("R7 cpu run follows stop", {31'd0, cpu_run}, {31'd0, cpu_stop_n});
      chk("R8 pci run with free-run", {25'd0, pci_run}, {25'd0, exp_pci(pci_stop_n, pci_free)});
      chk("R9 fixed group runs", {31'd0, fix_run}, 32'd1);
      chk("R10 driver enable", {31'd0, drv_en}, {31'd0, ~tri_all});
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pci_free = '0; tri_all = 1'b0;
    step(3);

    // R2 R3: entry latency and ordered shutdown
    pd_n = 1'b0;
    step(2);
    chk("R2 still running after 2 edges", {31'd0, fix_run}, 32'd1);
    step(1);
    chk("R2 parked after 3rd edge", parked_word(cpu_run, pci_run, fix_run), 32'd0);
    for (int k = 0; k < PARK; k++) begin
      chk("R3 osc held while parked", {30'd0, osc_en, vco_en}, 32'd3);
      step(1);
    end
    chk("R3 enables dropped after park", {30'd0, osc_en, vco_en}, 32'd0);
    chk("R3 off status", {31'd0, pd_off}, 32'd1);

    // R6: stops and free-run ignored while off; R10 still applies
    for (int i = 0; i < 12; i++) begin
      cpu_stop_n = 1'($urandom);
      pci_stop_n = 1'($urandom);
      pci_free   = NP'($urandom);
      tri_all    = 1'($urandom);
      step(1);
      chk("R6 outputs unaffected while off",
          parked_word(cpu_run, pci_run, fix_run) | {pd_off, 31'd0}, 32'h8000_0000);
      chk("R10 driver enable while off", {31'd0, drv_en}, {31'd0, ~tri_all});
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pci_free = '0; tri_all = 1'b0;

    wake("second");

    // R11: pin released during parking still completes the shutdown
    pd_n = 1'b0;
    step(3);
    chk("R11 parked", {31'd0, fix_run}, 32'd0);
    pd_n = 1'b1;
    step(PARK);
    chk("R11 reached off despite release", {31'd0, pd_off}, 32'd1);
    begin
      int g = 0;
      while (!fix_run && g < 2000) begin step(1); g++; end
      chk("R11 wakes afterwards", {31'd0, fix_run}, 32'd1);
    end

    // R5: power-down during the stabilisation wait
    pd_n = 1'b0;
    step(3 + PARK);
    chk("R5 off before abort test", {31'd0, pd_off}, 32'd1);
    pd_n = 1'b1;
    step(3);
    chk("R5 in wake wait", {30'd0, osc_en, fix_run}, 32'd2);
    pd_n = 1'b0;
    begin
      bit leaked = 1'b0;
      for (int i = 0; i < 20; i++) begin
        step(1);
        if (cpu_run || fix_run || pci_run != '0) leaked = 1'b1;
      end
      chk("R5 no release during abort", {31'd0, leaked}, 32'd0);
      chk("R5 back to off", {31'd0, pd_off}, 32'd1);
    end

    wake("third");
    chk("R7 cpu runs after final wake", {31'd0, cpu_run}, 32'd1);

    done = 1'b1;
    summary();
  end
endmodule